// File: doc/BRIEF.md
# Serial Background Debug Command Port

This block is a debug port that sits beside a processor core. A host shifts fixed 17-bit command frames into it over a synchronous serial link made of a clock, a data-in line and a data-out line. The port can halt the core by holding a freeze output high. While the core is halted, the port can read and write core registers and memory through a small request/acknowledge bus. Halting is silent. The core never sees an exception or an interrupt; it just stalls while the freeze output is high.

There are three ways into the halted state. The core can pulse a background-request input when it executes its background opcode. The port can be halted by holding the serial clock high for a long time while the core runs. A completed single step also returns the core to the halted state. The only way out is a GO command. A STEP command releases the core until it reports one retired instruction, and then the port freezes it again.

Each frame returns a response word, shifted out MSB first during the frame that follows it. The top bit of the response is a status bit: 0 means valid and 1 means not-ready or rejected. The other bits carry read data. The serial clock and data pass through a two-flop synchronizer into the system clock domain.

Top module: `bgdbg_port`

## Requirements
- R1: After reset, freeze, step and the access request are all low (the core runs) and serial data out is 0.
- R2: A frame is 17 bits, sampled on rising serial clock edges, MSB first. A command takes effect only after its 17th bit. Its response word leaves on serial data out MSB first during the next frame, with bit 16 as the status bit.
- R3: A one-cycle pulse on the background-request input while the core runs raises freeze on the next clock.
- R4: While the core runs, holding the serial clock high for HOLD_CYC system clocks raises freeze and discards the partly shifted frame. Normal short serial clock pulses never freeze the core.
- R5: GO (bits 16:13 = 5) leaves the halted state and lowers freeze after its frame, with status 0. GO while running is accepted with status 0 and has no effect.
- R6: STEP (opcode 6) while halted lowers freeze and raises the step output. The first instruction-done pulse after that raises freeze and lowers step again. STEP while running is accepted with no effect.
- R7: Register read (opcode 1) and register write (opcode 2) address a register with frame bits 12:0. A write takes one more frame, whose bits 15:0 are the data. The access is issued with the memory-select output low.
- R8: Memory read (opcode 3) and memory write (opcode 4) behave like R7, with the memory-select output high.
- R9: A read returns {0, data} in the next frame if the acknowledge arrives before that frame's first bit. Otherwise that frame returns status 1 and the data is dropped.
- R10: While the port is not halted, every opcode except GO and STEP is answered with status 1 and starts no access.
- R11: Opcodes 7 to 15 are illegal and are always answered with status 1 and no effect. NOP (opcode 0) while halted answers status 0.
- R12: The access request, with its address, stays asserted and stable until acknowledged. Any command frame that arrives while an access is outstanding is answered with status 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_sclk | input | 1 | Serial clock from host; a long high level requests a halt |
| dbg_sdi | input | 1 | Serial command data from host |
| dbg_sdo | output | 1 | Serial response data to host |
| dbg_freeze | output | 1 | High while the core is held halted |
| dbg_step | output | 1 | High while the core is released for one instruction |
| core_bgnd | input | 1 | Pulse from core on executing its background opcode |
| core_insn_done | input | 1 | Pulse from core when an instruction retires |
| acc_req | output | 1 | Access request to core |
| acc_we | output | 1 | Access is a write |
| acc_mem | output | 1 | Access targets memory (1) or a register (0) |
| acc_addr | output | 13 | Access address |
| acc_wdata | output | 16 | Write data |
| acc_ack | input | 1 | One-cycle access acknowledge |
| acc_rdata | input | 16 | Read data, valid with acc_ack |

## Verification
The bench builds the port with the default 17-bit frame and two synchronizer stages, but lowers HOLD_CYC to 8. With that value the hold-to-halt path can be triggered with a short pulse, while the bench's 3-cycle serial clock pulses stay safely below the limit. It sweeps all sixteen opcodes in both the running and halted states. It writes every one of 8 register addresses and 16 memory addresses with distinct computed values and reads them all back, so a routing mix-up between register and memory shows up. Acknowledge latency is a bench variable: a long value opens the not-ready and busy-rejection windows, and a short value covers normal reads.

// File: rtl/bgdbg_pkg.sv
package bgdbg_pkg;

    localparam int OPW = 4;

    localparam logic [OPW-1:0] OP_NOP   = 4'd0;
    localparam logic [OPW-1:0] OP_RDREG = 4'd1;
    localparam logic [OPW-1:0] OP_WRREG = 4'd2;
    localparam logic [OPW-1:0] OP_RDMEM = 4'd3;
    localparam logic [OPW-1:0] OP_WRMEM = 4'd4;
    localparam logic [OPW-1:0] OP_GO    = 4'd5;
    localparam logic [OPW-1:0] OP_STEP  = 4'd6;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_STEP = 2'd2
    } run_state_e;

endpackage

// File: rtl/bgdbg_sync.sv
module bgdbg_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/bgdbg_frame.sv
module bgdbg_frame #(
    parameter int FW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          sdi_s,
    input  logic          clear_i,
    input  logic          load_i,
    input  logic [FW-1:0] load_word_i,
    output logic          sdo_o,
    output logic          rise_o,
    output logic          done_o,
    output logic          idle_o,
    output logic [FW-1:0] word_o
);

    localparam int CW = $clog2(FW);

    typedef struct packed {
        logic [FW-2:0] rx;
        logic [FW-1:0] tx;
        logic [CW-1:0] cnt;
        logic          prev;
    } frm_t;

    frm_t q, d;
    logic rise, last;

    always_comb begin
        rise   = sclk_s & ~q.prev;
        last   = (q.cnt == CW'(FW-1));
        d      = q;
        d.prev = sclk_s;
        if (rise) begin
            d.rx  = {q.rx[FW-3:0], sdi_s};
            d.tx  = {q.tx[FW-2:0], 1'b0};
            d.cnt = last ? '0 : q.cnt + 1'b1;
        end
        if (clear_i) begin
            d.rx  = '0;
            d.cnt = '0;
        end
        if (load_i) begin
            d.tx = load_word_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdo_o  = q.tx[FW-1];
    assign rise_o = rise;
    assign done_o = rise & last;
    assign idle_o = (q.cnt == '0) & ~rise;
    assign word_o = {q.rx, sdi_s};

endmodule

// File: rtl/bgdbg_ctrl.sv
module bgdbg_ctrl
    import bgdbg_pkg::*;
#(
    parameter int FW       = 17,
    parameter int HOLD_CYC = 16,
    localparam int AW      = FW - OPW,
    localparam int DW      = FW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          rise_i,
    input  logic          done_i,
    input  logic          idle_i,
    input  logic [FW-1:0] word_i,
    output logic          clear_o,
    output logic          load_o,
    output logic [FW-1:0] load_word_o,
    input  logic          bgnd_i,
    input  logic          insn_done_i,
    output logic          freeze_o,
    output logic          step_o,
    output logic          acc_req,
    output logic          acc_we,
    output logic          acc_mem,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] acc_wdata,
    input  logic          acc_ack,
    input  logic [DW-1:0] acc_rdata
);

    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [FW-1:0] RSP_OK  = '0;
    localparam logic [FW-1:0] RSP_ERR = {1'b1, {DW{1'b0}}};

    typedef struct packed {
        run_state_e    st;
        logic          await_wr;
        logic          wr_mem;
        logic          read_pend;
        logic          req;
        logic          we;
        logic          mem;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [HW-1:0] hold;
    } ctl_t;

    ctl_t q, d;
    logic [OPW-1:0] op;

    always_comb begin
        d           = q;
        clear_o     = 1'b0;
        load_o      = 1'b0;
        load_word_o = RSP_OK;
        op          = word_i[FW-1 -: OPW];

        if (rise_i)  d.read_pend = 1'b0;
        if (acc_ack) begin
            d.req       = 1'b0;
            d.read_pend = 1'b0;
            if (q.read_pend && idle_i) begin
                load_o      = 1'b1;
                load_word_o = {1'b0, acc_rdata};
            end
        end

        if (done_i) begin
            load_o      = 1'b1;
            load_word_o = RSP_OK;
            if (q.await_wr) begin
                d.await_wr = 1'b0;
                d.req      = 1'b1;
                d.we       = 1'b1;
                d.mem      = q.wr_mem;
                d.wdata    = word_i[DW-1:0];
            end else if (op > OP_STEP || q.req) begin
                load_word_o = RSP_ERR;
            end else if (op == OP_GO) begin
                d.st = ST_RUN;
            end else if (op == OP_STEP) begin
                if (q.st == ST_HALT) d.st = ST_STEP;
            end else if (q.st != ST_HALT) begin
                load_word_o = RSP_ERR;
            end else if (op == OP_RDREG || op == OP_RDMEM) begin
                d.req       = 1'b1;
                d.we        = 1'b0;
                d.mem       = (op == OP_RDMEM);
                d.addr      = word_i[AW-1:0];
                d.read_pend = 1'b1;
                load_word_o = RSP_ERR;
            end else if (op == OP_WRREG || op == OP_WRMEM) begin
                d.await_wr = 1'b1;
                d.wr_mem   = (op == OP_WRMEM);
                d.addr     = word_i[AW-1:0];
            end
        end

        if (q.st == ST_RUN && sclk_s) begin
            if (q.hold < HW'(HOLD_CYC)) d.hold = q.hold + 1'b1;
            if (q.hold == HW'(HOLD_CYC - 1)) begin
                d.st    = ST_HALT;
                clear_o = 1'b1;
            end
        end else begin
            d.hold = '0;
        end

        if (q.st == ST_RUN && bgnd_i)       d.st = ST_HALT;
        if (q.st == ST_STEP && insn_done_i) d.st = ST_HALT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_RUN;
        end else begin
            q <= d;
        end
    end

    assign freeze_o  = (q.st == ST_HALT);
    assign step_o    = (q.st == ST_STEP);
    assign acc_req   = q.req;
    assign acc_we    = q.we;
    assign acc_mem   = q.mem;
    assign acc_addr  = q.addr;
    assign acc_wdata = q.wdata;

endmodule

// File: rtl/bgdbg_port.sv
module bgdbg_port
    import bgdbg_pkg::*;
#(
    parameter int FW          = 17,
    parameter int HOLD_CYC    = 16,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = FW - OPW,
    localparam int DW         = FW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dbg_sclk,
    input  logic          dbg_sdi,
    output logic          dbg_sdo,
    output logic          dbg_freeze,
    output logic          dbg_step,
    input  logic          core_bgnd,
    input  logic          core_insn_done,
    output logic          acc_req,
    output logic          acc_we,
    output logic          acc_mem,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] acc_wdata,
    input  logic          acc_ack,
    input  logic [DW-1:0] acc_rdata
);

    logic [1:0]    pins_s;
    logic          rise, done, idle, clear, load;
    logic [FW-1:0] word, load_word;

    bgdbg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({dbg_sclk, dbg_sdi}),
        .sync_o  (pins_s)
    );

    bgdbg_frame #(.FW(FW)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s      (pins_s[1]),
        .sdi_s       (pins_s[0]),
        .clear_i     (clear),
        .load_i      (load),
        .load_word_i (load_word),
        .sdo_o       (dbg_sdo),
        .rise_o      (rise),
        .done_o      (done),
        .idle_o      (idle),
        .word_o      (word)
    );

    bgdbg_ctrl #(.FW(FW), .HOLD_CYC(HOLD_CYC)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s      (pins_s[1]),
        .rise_i      (rise),
        .done_i      (done),
        .idle_i      (idle),
        .word_i      (word),
        .clear_o     (clear),
        .load_o      (load),
        .load_word_o (load_word),
        .bgnd_i      (core_bgnd),
        .insn_done_i (core_insn_done),
        .freeze_o    (dbg_freeze),
        .step_o      (dbg_step),
        .acc_req     (acc_req),
        .acc_we      (acc_we),
        .acc_mem     (acc_mem),
        .acc_addr    (acc_addr),
        .acc_wdata   (acc_wdata),
        .acc_ack     (acc_ack),
        .acc_rdata   (acc_rdata)
    );

endmodule

// File: rtl/bgdbg_port_chk.sv
module bgdbg_port_chk #(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dbg_freeze,
    input logic          dbg_step,
    input logic          core_bgnd,
    input logic          core_insn_done,
    input logic          acc_req,
    input logic          acc_ack,
    input logic [AW-1:0] acc_addr
);

    a_r3_bgnd_halts: assert property (@(posedge clk) disable iff (!rst_n)
        core_bgnd && !dbg_freeze && !dbg_step |=> dbg_freeze);

    a_r6_step_refreezes: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_step && core_insn_done |=> dbg_freeze && !dbg_step);

    a_r6_step_not_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !(dbg_step && dbg_freeze));

    a_r10_access_only_halted: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |-> dbg_freeze);

    a_r12_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && !acc_ack |=> acc_req && $stable(acc_addr));

endmodule

bind bgdbg_port bgdbg_port_chk #(.AW(AW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .dbg_freeze     (dbg_freeze),
    .dbg_step       (dbg_step),
    .core_bgnd      (core_bgnd),
    .core_insn_done (core_insn_done),
    .acc_req        (acc_req),
    .acc_ack        (acc_ack),
    .acc_addr       (acc_addr)
);

// File: tb/bgdbg_port_test.sv
module bgdbg_port_test;

    localparam logic [16:0] RSP_ERR = 17'h10000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, sdi = 1'b0, sdo;
    logic        freeze, step;
    logic        bgnd = 1'b0, insn = 1'b0;
    logic        acc_req, acc_we, acc_mem, acc_ack;
    logic [12:0] acc_addr;
    logic [15:0] acc_wdata, acc_rdata;

    int errors = 0, checks = 0, ack_delay = 1, req_starts = 0, dcnt = 0;
    bit finished = 0;
    logic [15:0] regs [8];
    logic [15:0] mem  [16];
    logic        req_prev = 1'b0;

    always #5 clk = ~clk;

    bgdbg_port #(.HOLD_CYC(8)) uut (
        .clk(clk), .rst_n(rst_n), .dbg_sclk(sclk), .dbg_sdi(sdi), .dbg_sdo(sdo),
        .dbg_freeze(freeze), .dbg_step(step), .core_bgnd(bgnd), .core_insn_done(insn),
        .acc_req(acc_req), .acc_we(acc_we), .acc_mem(acc_mem), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_ack(acc_ack), .acc_rdata(acc_rdata)
    );

    // core access model with adjustable latency
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_ack <= 1'b0; acc_rdata <= '0; dcnt <= 0; req_prev <= 1'b0; req_starts <= 0;
        end else begin
            req_prev <= acc_req;
            if (acc_req && !req_prev) req_starts <= req_starts + 1;
            if (acc_ack) acc_ack <= 1'b0;
            else if (acc_req) begin
                if (dcnt >= ack_delay) begin
                    acc_ack <= 1'b1;
                    dcnt <= 0;
                    if (acc_we) begin
                        if (acc_mem) mem[acc_addr[3:0]] <= acc_wdata;
                        else         regs[acc_addr[2:0]] <= acc_wdata;
                    end else begin
                        acc_rdata <= acc_mem ? mem[acc_addr[3:0]] : regs[acc_addr[2:0]];
                    end
                end else dcnt <= dcnt + 1;
            end
        end
    end

    function automatic logic [15:0] rv(int a);
        return 16'(a * 16'h2345 + 16'h0011);
    endfunction
    function automatic logic [15:0] mv(int a);
        return 16'((a * 16'h0F13) ^ 16'hC3A5);
    endfunction
    function automatic logic [16:0] mk(int op, int addr);
        return {4'(op), 13'(addr)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [16:0] w, output logic [16:0] r);
        for (int i = 16; i >= 0; i--) begin
            @(negedge clk); sdi = w[i];
            repeat (3) @(negedge clk);
            r[i] = sdo; sclk = 1'b1;
            repeat (3) @(negedge clk);
            sclk = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [16:0] r;
        for (int i = 0; i < 8; i++)  regs[i] = '0;
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 freeze", freeze, 0);
        check("R1 step", step, 0);
        check("R1 acc_req", acc_req, 0);
        check("R1 sdo", sdo, 0);

        // R10 R11 running: all but GO/STEP rejected
        for (int op = 0; op < 16; op++) begin
            if (op == 5 || op == 6) continue;
            xfer(mk(op, op), r);
            xfer(mk(5, 0), r);
            check($sformatf("R10 run op %0d status", op), r, RSP_ERR);
        end
        check("R10 no access while running", req_starts, 0);
        check("R4 short pulses keep running", freeze, 0);
        xfer(mk(5, 0), r);
        xfer(mk(6, 0), r);
        check("R5 GO while running", r, 0);
        xfer(mk(5, 0), r);
        check("R6 STEP while running", r, 0);
        check("R6 step low while running", step, 0);

        // R3 background request
        @(negedge clk); bgnd = 1'b1;
        @(negedge clk); bgnd = 1'b0;
        check("R3 freeze after bgnd", freeze, 1);

        // R5 GO leaves halt
        xfer(mk(5, 0), r);
        check("R5 freeze low after GO", freeze, 0);
        xfer(mk(5, 0), r);
        check("R5 GO status", r, 0);

        // R4 hold-high break, partial frame discarded
        @(negedge clk); sclk = 1'b1;
        repeat (14) @(negedge clk);
        sclk = 1'b0;
        repeat (6) @(negedge clk);
        check("R4 freeze after hold", freeze, 1);

        // R11 illegal and NOP while halted
        xfer(mk(0, 0), r);
        xfer(mk(0, 0), r);
        check("R11 NOP halted status", r, 0);
        for (int op = 7; op < 16; op++) begin
            xfer(mk(op, 1), r);
            xfer(mk(0, 0), r);
            check($sformatf("R11 illegal op %0d", op), r, RSP_ERR);
        end
        check("R11 no access from illegal", req_starts, 0);

        // R7 R8 write sweep
        for (int a = 0; a < 8; a++) begin
            xfer(mk(2, a), r);
            xfer({1'b0, rv(a)}, r);
            check($sformatf("R7 wr reg %0d cmd status", a), r, 0);
        end
        for (int a = 0; a < 16; a++) begin
            xfer(mk(4, a), r);
            xfer({1'b0, mv(a)}, r);
            check($sformatf("R8 wr mem %0d cmd status", a), r, 0);
        end
        // R2 R7 R8 R9 read-back sweep
        for (int a = 0; a < 8; a++) begin
            xfer(mk(1, a), r);
            xfer(mk(0, 0), r);
            check($sformatf("R7 R9 rd reg %0d", a), r, {1'b0, rv(a)});
        end
        for (int a = 0; a < 16; a++) begin
            xfer(mk(3, a), r);
            xfer(mk(0, 0), r);
            check($sformatf("R8 R2 rd mem %0d", a), r, {1'b0, mv(a)});
        end

        // R9 not ready, R12 busy rejection
        ack_delay = 600;
        xfer(mk(1, 3), r);
        xfer(mk(2, 0), r);
        check("R9 late ack not ready", r, RSP_ERR);
        xfer(mk(0, 0), r);
        check("R12 busy rejects command", r, RSP_ERR);
        while (acc_req) @(negedge clk);
        ack_delay = 1;
        xfer(mk(0, 0), r);
        xfer(mk(1, 0), r);
        xfer(mk(0, 0), r);
        check("R12 rejected write left reg 0", r, {1'b0, rv(0)});

        // R6 single step
        xfer(mk(6, 0), r);
        check("R6 freeze low in step", freeze, 0);
        check("R6 step high", step, 1);
        repeat (5) @(negedge clk);
        insn = 1'b1;
        @(negedge clk); insn = 1'b0;
        check("R6 refrozen", freeze, 1);
        check("R6 step low", step, 0);
        xfer(mk(0, 0), r);
        check("R6 STEP status", r, 0);

        xfer(mk(5, 0), r);
        check("R5 final GO", freeze, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule